// File: doc/BRIEF.md
# Nonvolatile Array Refresh Sequencer

This block is a hardware engine that renews every byte of a byte-addressable nonvolatile data array. For each byte, it reads the stored value into the write controller's data holding register and then commits that same value back. The engine talks to the guarded write controller only through that controller's register write port. It issues the same register writes, in the same order, that a software refresh loop would issue.

After a start pulse, the engine masks interrupts and turns on write permission. It then steps through every location, from address zero up to the point where the two-part address wraps. At each location it loads the address, requests a read, presents the two-byte unlock key and sets the start bit. It then waits until the controller drops its busy flag. When the sweep is complete, the engine removes write permission, unmasks interrupts and emits a single-cycle done pulse.

The address is split into a low part and a high part. Each part has a parameterized width, at most 8 bits. Narrow widths give a short sweep.

Top module: `nv_refresh_seq`

## Requirements
- R1: The first location visited is address zero: its low-address write carries 0x00 and its high-address write carries 0x00.
- R2: `irq_mask` rises with the first register write of a refresh (a control write of 0x04, write-enable only). It stays high for every register write of that refresh, including the final control write.
- R3: Each location produces six register writes on consecutive cycles, in this order: low address (sel 0), high address (sel 1), control 0x05 (read bit 0 plus write-enable bit 2, sel 2), key 0x55 (sel 3), key 0xAA (sel 3), and control 0x06 (start bit 1 plus write-enable bit 2, sel 2).
- R4: After the control write that sets the start bit, no register write is issued while `ctrl_busy` is high. The next location's writes begin in the cycle after `ctrl_busy` is first sampled low.
- R5: The low address increments after each location. When the low address wraps to zero, the high address increments. The sweep ends when the high address wraps, so exactly 2^(LO_BITS+HI_BITS) locations are visited, each exactly once.
- R6: After the last location, the engine issues one control write of 0x00 (write permission off). In the next cycle, `done` is high and `irq_mask` is low.
- R7: `done` lasts exactly one cycle per refresh. A `start` received while a refresh is running (including a held start) causes no extra writes and no extra done pulse.
- R8: While reset is held and after its release, all outputs are low until a start is seen.
- R9: With a controller that writes back its holding register, every byte of the array holds its original value after the refresh.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request to begin a refresh (taken only when idle) |
| ctrl_busy | input | 1 | Controller write-in-progress flag |
| reg_wr_en | output | 1 | Register write strobe to the controller |
| reg_wr_sel | output | 2 | Register select: 0 low address, 1 high address, 2 control, 3 key |
| reg_wr_data | output | 8 | Register write data |
| irq_mask | output | 1 | High while interrupts must stay masked |
| done | output | 1 | One-cycle pulse when a refresh ends |

## Verification
The hardest case to reach from the ports is a start request that arrives while the engine is waiting on a busy controller in the middle of the sweep. A second hard case is a busy period whose length differs from one location to the next. The bench models the controller with a busy time that depends on the low address. It runs two sweeps with different busy lengths and pulses or holds `start` partway through each sweep. The scoreboard then confirms that the expected stream of register writes is neither extended nor repeated.

// File: rtl/nv_refresh_pkg.sv
// Shared encodings for the array refresh sequencer.
// Assumes an 8-bit register port on the guarded write controller.
package nv_refresh_pkg;
    localparam int DATA_W = 8;

    typedef enum logic [1:0] {
        SEL_ADDR_LO = 2'd0,
        SEL_ADDR_HI = 2'd1,
        SEL_CTRL    = 2'd2,
        SEL_KEY     = 2'd3
    } reg_sel_e;

    localparam logic [DATA_W-1:0] CTRL_WREN     = 8'h04;
    localparam logic [DATA_W-1:0] CTRL_RD_WREN  = 8'h05;
    localparam logic [DATA_W-1:0] CTRL_GO_WREN  = 8'h06;
    localparam logic [DATA_W-1:0] CTRL_OFF      = 8'h00;
    localparam logic [DATA_W-1:0] KEY_FIRST     = 8'h55;
    localparam logic [DATA_W-1:0] KEY_SECOND    = 8'hAA;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ENABLE,
        ST_LOAD_LO,
        ST_LOAD_HI,
        ST_READ,
        ST_KEY_A,
        ST_KEY_B,
        ST_COMMIT,
        ST_WAIT,
        ST_DISABLE,
        ST_DONE
    } seq_state_e;
endpackage

// File: rtl/nv_refresh_addr_ctr.sv
// One part of the carried refresh address.
// Clears on request and increments when told to.
// The carry output is high when an increment wraps this part to zero.
// Assumes clr and inc are never high together in a useful cycle; clr wins.
module nv_refresh_addr_ctr #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] value,
    output logic         carry
);
    localparam logic [W-1:0] ALL_ONES = '1;

    // Carry out when this increment rolls the part over.
    assign carry = inc && (value == ALL_ONES);

    // Holds and advances this part of the address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value <= '0;
        end else if (clr) begin
            value <= '0;
        end else if (inc) begin
            value <= value + 1'b1;
        end
    end
endmodule

// File: rtl/nv_refresh_fsm.sv
// Step sequencer for the refresh.
// Emits one controller register write per state, waits on busy after each commit,
// and finishes when the address counter reports the final wrap.
// Assumes busy is raised by the controller in the cycle after the commit write.
module nv_refresh_fsm
    import nv_refresh_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              busy,
    input  logic              last_wrap,
    output logic              ctr_clr,
    output logic              ctr_step,
    output logic              wr_en,
    output reg_sel_e          wr_sel,
    output logic [DATA_W-1:0] wr_const,
    output logic              use_lo,
    output logic              use_hi,
    output logic              mask_irq,
    output logic              fin_pulse
);
    seq_state_e state, state_nx;

    // Start is honoured only from idle.
    assign ctr_clr  = (state == ST_IDLE) && start;
    // Address advances when the wait for a location is over.
    assign ctr_step = (state == ST_WAIT) && !busy;

    // Next-state selection.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (start) state_nx = ST_ENABLE;
            ST_ENABLE:  state_nx = ST_LOAD_LO;
            ST_LOAD_LO: state_nx = ST_LOAD_HI;
            ST_LOAD_HI: state_nx = ST_READ;
            ST_READ:    state_nx = ST_KEY_A;
            ST_KEY_A:   state_nx = ST_KEY_B;
            ST_KEY_B:   state_nx = ST_COMMIT;
            ST_COMMIT:  state_nx = ST_WAIT;
            ST_WAIT:    if (!busy) state_nx = last_wrap ? ST_DISABLE : ST_LOAD_LO;
            ST_DISABLE: state_nx = ST_DONE;
            ST_DONE:    state_nx = ST_IDLE;
            default:    state_nx = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Register write decode for the current state.
    always_comb begin
        wr_en    = 1'b1;
        wr_sel   = SEL_CTRL;
        wr_const = CTRL_OFF;
        use_lo   = 1'b0;
        use_hi   = 1'b0;
        unique case (state)
            ST_ENABLE:  wr_const = CTRL_WREN;
            ST_LOAD_LO: begin wr_sel = SEL_ADDR_LO; use_lo = 1'b1; end
            ST_LOAD_HI: begin wr_sel = SEL_ADDR_HI; use_hi = 1'b1; end
            ST_READ:    wr_const = CTRL_RD_WREN;
            ST_KEY_A:   begin wr_sel = SEL_KEY; wr_const = KEY_FIRST; end
            ST_KEY_B:   begin wr_sel = SEL_KEY; wr_const = KEY_SECOND; end
            ST_COMMIT:  wr_const = CTRL_GO_WREN;
            ST_DISABLE: wr_const = CTRL_OFF;
            default:    wr_en = 1'b0;
        endcase
    end

    // Interrupt mask covers every state between idle and the done cycle.
    assign mask_irq  = (state != ST_IDLE) && (state != ST_DONE);
    assign fin_pulse = (state == ST_DONE);
endmodule

// File: rtl/nv_refresh_seq.sv
// Top of the array refresh sequencer.
// Chains a low and a high address counter and drives the controller register port
// from the step sequencer.
// Assumes LO_BITS and HI_BITS are each between 1 and 8.
module nv_refresh_seq
    import nv_refresh_pkg::*;
#(
    parameter int LO_BITS = 8,
    parameter int HI_BITS = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       ctrl_busy,
    output logic       reg_wr_en,
    output logic [1:0] reg_wr_sel,
    output logic [7:0] reg_wr_data,
    output logic       irq_mask,
    output logic       done
);
    localparam int PARTS = 2;

    logic [LO_BITS-1:0] addr_lo;
    logic [HI_BITS-1:0] addr_hi;
    logic [PARTS:0]     inc_chain;
    logic               ctr_clr;
    logic               wrap_lo;
    logic               wrap_hi;
    logic               wr_en;
    reg_sel_e           wr_sel;
    logic [DATA_W-1:0]  wr_const;
    logic               use_lo;
    logic               use_hi;

    // Low part advances on each step; high part advances on the low carry.
    assign inc_chain[1] = wrap_lo;
    assign inc_chain[2] = wrap_hi;

    nv_refresh_addr_ctr #(.W(LO_BITS)) u_ctr_lo (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (ctr_clr),
        .inc   (inc_chain[0]),
        .value (addr_lo),
        .carry (wrap_lo)
    );

    nv_refresh_addr_ctr #(.W(HI_BITS)) u_ctr_hi (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (ctr_clr),
        .inc   (inc_chain[1]),
        .value (addr_hi),
        .carry (wrap_hi)
    );

    nv_refresh_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .busy      (ctrl_busy),
        .last_wrap (inc_chain[PARTS]),
        .ctr_clr   (ctr_clr),
        .ctr_step  (inc_chain[0]),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_const  (wr_const),
        .use_lo    (use_lo),
        .use_hi    (use_hi),
        .mask_irq  (irq_mask),
        .fin_pulse (done)
    );

    // Write data: an address part, zero-extended, or a sequencer constant.
    always_comb begin
        if (use_lo) begin
            reg_wr_data = DATA_W'(addr_lo);
        end else if (use_hi) begin
            reg_wr_data = DATA_W'(addr_hi);
        end else begin
            reg_wr_data = wr_const;
        end
    end

    assign reg_wr_en  = wr_en;
    assign reg_wr_sel = wr_sel;
endmodule

// File: rtl/nv_refresh_seq_chk.sv
// Protocol checker for the refresh sequencer.
// Bound to the top module and observes the top module's ports only.
module nv_refresh_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ctrl_busy,
    input logic       reg_wr_en,
    input logic [1:0] reg_wr_sel,
    input logic [7:0] reg_wr_data,
    input logic       irq_mask,
    input logic       done
);
    // R2
    mask_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |-> irq_mask);

    // R3
    key_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && reg_wr_sel == 2'd3 && reg_wr_data == 8'hAA)
        |-> $past(reg_wr_en && reg_wr_sel == 2'd3 && reg_wr_data == 8'h55));

    // R4
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_busy |=> !reg_wr_en);

    // R6
    final_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(reg_wr_en && reg_wr_sel == 2'd2 && reg_wr_data == 8'h00) && !irq_mask));

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!reg_wr_en && !irq_mask && !done));
endmodule

bind nv_refresh_seq nv_refresh_seq_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctrl_busy   (ctrl_busy),
    .reg_wr_en   (reg_wr_en),
    .reg_wr_sel  (reg_wr_sel),
    .reg_wr_data (reg_wr_data),
    .irq_mask    (irq_mask),
    .done        (done)
);

// File: tb/nv_refresh_seq_bench.sv
// Scoreboard bench: the driver queues the expected register writes, and the
// monitor compares them against the design while modelling the write controller.
module nv_refresh_seq_bench;
    localparam int LO_BITS = 3;
    localparam int HI_BITS = 2;
    localparam int DEPTH   = 1 << (LO_BITS + HI_BITS);

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       ctrl_busy = 1'b0;
    logic       reg_wr_en;
    logic [1:0] reg_wr_sel;
    logic [7:0] reg_wr_data;
    logic       irq_mask;
    logic       done;

    always #2 clk = ~clk;

    nv_refresh_seq #(.LO_BITS(LO_BITS), .HI_BITS(HI_BITS)) u_nv_refresh_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .ctrl_busy   (ctrl_busy),
        .reg_wr_en   (reg_wr_en),
        .reg_wr_sel  (reg_wr_sel),
        .reg_wr_data (reg_wr_data),
        .irq_mask    (irq_mask),
        .done        (done)
    );

    typedef struct {
        logic [1:0] sel;
        logic [7:0] data;
        string      tag;
    } item_t;

    item_t q[$];
    int    checks = 0;
    int    failures = 0;
    int    done_cnt = 0;
    int    commit_cnt = 0;
    int    lat_base = 2;
    logic [7:0] mem    [DEPTH];
    logic [7:0] golden [DEPTH];

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic push(input logic [1:0] sel, input logic [7:0] data, input string tag);
        item_t it;
        it.sel = sel; it.data = data; it.tag = tag;
        q.push_back(it);
    endtask

    // Driver: expected write stream of one full refresh.
    task automatic push_run();
        push(2'd2, 8'h04, "R2");
        for (int hi = 0; hi < (1 << HI_BITS); hi++) begin
            for (int lo = 0; lo < (1 << LO_BITS); lo++) begin
                push(2'd0, 8'(lo), (hi == 0 && lo == 0) ? "R1" : "R5");
                push(2'd1, 8'(hi), (hi == 0 && lo == 0) ? "R1" : "R5");
                push(2'd2, 8'h05, "R3");
                push(2'd3, 8'h55, "R3");
                push(2'd3, 8'hAA, "R3");
                push(2'd2, 8'h06, "R3");
            end
        end
        push(2'd2, 8'h00, "R6");
    endtask

    // Monitor and controller model, evaluated between clock edges.
    initial begin
        logic [7:0] m_lo, m_hi, m_dat;
        int   key_st, busy_cnt, pend_idx, idx;
        logic m_wren, prev_done;
        item_t it;
        m_lo = 0; m_hi = 0; m_dat = 0; key_st = 0; busy_cnt = 0;
        pend_idx = 0; m_wren = 0; prev_done = 0;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                idx = int'(m_hi) * (1 << LO_BITS) + int'(m_lo);
                if (reg_wr_en) begin
                    check(irq_mask === 1'b1, "R2", "irq_mask during write", irq_mask, 1);
                    check(ctrl_busy === 1'b0, "R4", "write while busy", ctrl_busy, 0);
                    if (q.size() == 0) begin
                        check(1'b0, "R7", "unexpected write", reg_wr_data, 0);
                    end else begin
                        it = q.pop_front();
                        check(reg_wr_sel === it.sel, it.tag, "select", reg_wr_sel, it.sel);
                        check(reg_wr_data === it.data, it.tag, "data", reg_wr_data, it.data);
                    end
                    case (reg_wr_sel)
                        2'd0: begin m_lo = reg_wr_data; key_st = 0; end
                        2'd1: begin m_hi = reg_wr_data; key_st = 0; end
                        2'd3: key_st = (reg_wr_data == 8'h55) ? 1 :
                                       ((reg_wr_data == 8'hAA && key_st == 1) ? 2 : 0);
                        default: begin
                            m_wren = reg_wr_data[2];
                            if (reg_wr_data[0]) m_dat = mem[idx % DEPTH];
                            if (reg_wr_data[1] && m_wren && key_st == 2) begin
                                ctrl_busy = 1'b1;
                                busy_cnt  = lat_base + int'(m_lo) % 3;
                                pend_idx  = idx % DEPTH;
                            end
                            key_st = 0;
                        end
                    endcase
                end else if (ctrl_busy) begin
                    busy_cnt--;
                    if (busy_cnt <= 0) begin
                        mem[pend_idx] = m_dat;
                        commit_cnt++;
                        ctrl_busy = 1'b0;
                    end
                end
                if (done) begin
                    check(!prev_done, "R7", "done longer than one cycle", 1, 0);
                    check(irq_mask === 1'b0, "R6", "irq_mask at done", irq_mask, 0);
                    check(q.size() == 0, "R6", "writes left at done", q.size(), 0);
                    done_cnt++;
                end
                prev_done = done;
            end
        end
    end

    // One refresh with a start pulse at cycle stray_at lasting stray_len cycles.
    task automatic run_refresh(input int lat, input int hold, input int stray_at,
                               input string label);
        int d0, c0, cyc;
        lat_base = lat;
        d0 = done_cnt;
        c0 = commit_cnt;
        push_run();
        start = 1'b1;
        repeat (hold) @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (done_cnt == d0) begin
            @(negedge clk);
            cyc++;
            start = (cyc >= stray_at && cyc < stray_at + 2);
        end
        start = 1'b0;
        repeat (20) @(negedge clk);
        check(done_cnt - d0 == 1, "R7", {label, " done pulses"}, done_cnt - d0, 1);
        check(commit_cnt - c0 == DEPTH, "R5", {label, " locations committed"},
              commit_cnt - c0, DEPTH);
        check(irq_mask === 1'b0 && reg_wr_en === 1'b0, "R6", {label, " quiet after done"},
              {irq_mask, reg_wr_en}, 0);
        for (int i = 0; i < DEPTH; i++) begin
            check(mem[i] === golden[i], "R9", {label, " byte unchanged"}, mem[i], golden[i]);
        end
    endtask

    // Watchdog: a hung run is a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 100000, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            golden[i] = 8'((i * 37 + 5) % 256);
            mem[i]    = golden[i];
        end
        start = 1'b1;
        repeat (3) @(negedge clk);
        // R8: outputs low while reset is held, even with start high.
        check({reg_wr_en, irq_mask, done} === 3'b000, "R8", "outputs in reset",
              {reg_wr_en, irq_mask, done}, 0);
        start = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check({reg_wr_en, irq_mask, done} === 3'b000, "R8", "outputs after reset",
              {reg_wr_en, irq_mask, done}, 0);
        // Short busy periods; a stray start mid-sweep.
        run_refresh(2, 1, 40, "run1");
        // Longer busy periods; start held two cycles; stray start during a wait.
        run_refresh(5, 2, 123, "run2");
        check(q.size() == 0, "R7", "scoreboard drained", q.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule